// File: doc/BRIEF.md
# Serial Digital Video Scrambler Serializer

This block turns 10-bit parallel video words into a single serial bit stream. It runs on the bit clock, which is ten times the word rate. The block paces its own word intake: it raises a word strobe on every tenth bit-clock cycle, and on that cycle it takes the word from its parallel input. The bits of each word go out least significant bit first, and one word follows the next with no gap.

Each bit passes through a self-synchronising scrambler with generator x^9 + x^4 + 1. The scrambler keeps a nine-bit history of its own scrambled output. Each scrambled bit then enters an x + 1 differential stage that turns the NRZ stream into NRZI. A receiver can therefore recover the words from transitions alone, with no knowledge of polarity.

A lock input gates all progress. While lock is low, the serial line, the bit position and all polynomial state are frozen, and the stream resumes exactly where it stopped. Reset clears every register, clears the scrambler history and holds the output-enable low.

Top module: `sdvSerializer`

## Requirements
- R1: The bits of each word are emitted least significant bit first. The bit taken from `wordIn[0]` on the clock edge where `wordTick` is high is the first bit that affects `serOut` after that edge, and bit k follows on the k-th locked edge after it.
- R2: The scrambled bit is s(n) = d(n) XOR s(n-4) XOR s(n-9), where d is the data bit and s(n-k) is the scrambled bit produced k locked bit-times earlier.
- R3: On every advancing edge, `serOut` toggles when the scrambled bit is 1 and holds its value when the scrambled bit is 0.
- R4: Words follow each other with no gap. `wordTick` is high on exactly one cycle in every ten locked cycles, and it is high on the cycle right after bit 9 of the previous word was emitted.
- R5: While `locked` is low, `serOut` does not change and `wordTick` stays low. When `locked` returns high, the bit position and the scrambler and NRZI state continue from where they stopped.
- R6: While `rstN` is low, `serOut`, `serEn` and `wordTick` are all 0, and the scrambler history and NRZI state are cleared. After reset, a decoder that starts from all-zero state recovers the first word correctly from its first bit.
- R7: `serEn` is 1 from the first clock edge after reset is released. No bit is emitted on that first edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, ten times the word rate |
| rstN | input | 1 | Asynchronous active-low reset |
| locked | input | 1 | High when the bit clock source is locked; low freezes the block |
| wordIn | input | 10 | Parallel video word, sampled on the edge where wordTick is high |
| wordTick | output | 1 | High on the cycle in which wordIn is taken |
| serOut | output | 1 | NRZI-coded scrambled serial data |
| serEn | output | 1 | Serial output enable; low during reset |

## Verification
The bench decodes the serial line with its own NRZI decoder and descrambler and checks every recovered bit against the words it supplied. A swapped tap, a wrong bit order, or a toggle on zero instead of one therefore produces miscompares within the first few words. Lock is dropped in the middle of a word: a design that keeps shifting, or that skips or repeats a bit on resume, moves the output while it should be frozen or puts the decoded stream one bit off. A reset in the middle of a run catches a scrambler history or NRZI state that is not cleared, because the decoder restarts from zero and the first word would then come out corrupted. The patterns are all zeros, all ones, alternating bits, walking ones and a mixed count, so the long runs of equal bits and the dense toggling cases are both covered.

// File: rtl/sdv_pkg.sv
package sdv_pkg;
  // Strobes from control to datapath for one bit-clock cycle
  typedef struct packed {
    logic advance;  // emit one bit this cycle
    logic load;     // take a new word this cycle (implies advance)
  } sdvStrobes_t;
endpackage

// File: rtl/sdvCtrl.sv
module sdvCtrl
  import sdv_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        locked,
  output sdvStrobes_t strobes,
  output logic        outEn
);
  localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0] bitCnt;
  logic             running;

  always_comb begin
    strobes.advance = locked && running;
    strobes.load    = locked && running && (bitCnt == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      running <= 1'b0;
    end else begin
      running <= 1'b1;
      if (strobes.advance) begin
        if (bitCnt == LAST_BIT) bitCnt <= '0;
        else                    bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  assign outEn = running;
endmodule

// File: rtl/sdvDatapath.sv
module sdvDatapath
  import sdv_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int TAP_A  = 4,
  parameter int TAP_B  = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  sdvStrobes_t       strobes,
  input  logic [WORD_W-1:0] wordIn,
  output logic              serOut
);
  localparam int HIST_W = TAP_B;

  logic [WORD_W-1:0] shReg;
  logic [HIST_W-1:0] hist;   // hist[k] = scrambled bit k+1 bit-times ago
  logic              nrziQ;
  logic              dataBit;
  logic              scrBit;
  logic [WORD_W-1:0] shNext;

  always_comb begin
    if (strobes.load) begin
      dataBit = wordIn[0];
      shNext  = wordIn >> 1;
    end else begin
      dataBit = shReg[0];
      shNext  = shReg >> 1;
    end
    scrBit = dataBit ^ hist[TAP_A-1] ^ hist[TAP_B-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
      hist  <= '0;
      nrziQ <= 1'b0;
    end else if (strobes.advance) begin
      shReg <= shNext;
      hist  <= {hist[HIST_W-2:0], scrBit};
      nrziQ <= nrziQ ^ scrBit;
    end
  end

  assign serOut = nrziQ;
endmodule

// File: rtl/sdvSerializer.sv
module sdvSerializer
  import sdv_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int TAP_A  = 4,
  parameter int TAP_B  = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              locked,
  input  logic [WORD_W-1:0] wordIn,
  output logic              wordTick,
  output logic              serOut,
  output logic              serEn
);
  sdvStrobes_t strobes;

  sdvCtrl #(.WORD_W(WORD_W)) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .locked (locked),
    .strobes(strobes),
    .outEn  (serEn)
  );

  sdvDatapath #(.WORD_W(WORD_W), .TAP_A(TAP_A), .TAP_B(TAP_B)) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .wordIn (wordIn),
    .serOut (serOut)
  );

  assign wordTick = strobes.load;
endmodule

// File: rtl/sdvSerializer_chk.sv
module sdvSerializer_chk #(
  parameter int WORD_W = 10
) (
  input logic clk,
  input logic rstN,
  input logic locked,
  input logic wordTick,
  input logic serOut,
  input logic serEn
);
  localparam int GAP_W = $clog2(WORD_W + 1) + 1;

  logic [GAP_W-1:0] gapCnt;
  logic             seenTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt   <= '0;
      seenTick <= 1'b0;
    end else if (locked && serEn) begin
      if (wordTick) begin
        gapCnt   <= '0;
        seenTick <= 1'b1;
      end else begin
        gapCnt <= gapCnt + 1'b1;
      end
    end
  end

  // R5
  hold_unlocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    !locked |=> $stable(serOut));

  // R5
  tick_needs_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordTick |-> locked);

  // R4
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wordTick && seenTick) |-> (gapCnt == GAP_W'(WORD_W - 1)));

  // R7
  enable_after_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> serEn);

  // R5
  toggle_only_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(serOut) |-> $past(locked));
endmodule

bind sdvSerializer sdvSerializer_chk #(.WORD_W(WORD_W)) i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .locked  (locked),
  .wordTick(wordTick),
  .serOut  (serOut),
  .serEn   (serEn)
);

// File: tb/test_sdvSerializer.sv
module test_sdvSerializer;
  localparam int CLK_PERIOD = 10;
  localparam int WORD_W = 10;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              locked = 1'b1;
  logic [WORD_W-1:0] wordIn = '0;
  logic              wordTick;
  logic              serOut;
  logic              serEn;

  int  nVec = 0;
  int  nBad = 0;
  bit  expQ[$];
  int  wordIdx = 0;
  bit  finished = 0;

  // bench decoder state
  logic       prevOut = 1'b0;
  logic [8:0] dHist = '0;
  logic       advAtEdge;
  logic       rstAtEdge;

  sdvSerializer i_sdvSerializer (
    .clk(clk), .rstN(rstN), .locked(locked), .wordIn(wordIn),
    .wordTick(wordTick), .serOut(serOut), .serEn(serEn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [WORD_W-1:0] patWord(int i);
    if (i < 4)       return '0;
    else if (i < 8)  return '1;
    else if (i < 12) return (i % 2 == 0) ? 10'h2AA : 10'h155;
    else if (i < 22) return 10'(1 << (i - 12));
    else             return 10'((i * 37 + 5) & 10'h3FF);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    nVec++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: on a negedge where wordTick is high, present the next word
  task automatic runCycles(int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      if (wordTick) begin
        wordIn = patWord(wordIdx);
        for (int b = 0; b < WORD_W; b++) expQ.push_back(wordIn[b]);
        wordIdx++;
      end
    end
  endtask

  // Monitor: decode the bit emitted on the edge just passed
  always @(posedge clk) begin
    advAtEdge = locked && serEn && rstN;
    rstAtEdge = rstN;
    #(CLK_PERIOD/4);
    if (!rstN) begin
      check(serOut == 1'b0, "R6 serOut", int'(serOut), 0);
      check(serEn == 1'b0, "R6 serEn", int'(serEn), 0);
      check(wordTick == 1'b0, "R6 wordTick", int'(wordTick), 0);
      prevOut = 1'b0;
      dHist = '0;
    end else begin
      if (rstAtEdge)
        check(serEn == 1'b1, "R7 serEn", int'(serEn), 1);
      if (advAtEdge) begin
        logic s, d;
        bit e;
        s = serOut ^ prevOut;
        prevOut = serOut;
        d = s ^ dHist[3] ^ dHist[8];
        dHist = {dHist[7:0], s};
        if (expQ.size() == 0) begin
          check(1'b0, "R1 R4 queue empty", int'(d), -1);
        end else begin
          e = expQ.pop_front();
          check(d == e, "R1 R2 R3 R4 R6 recovered bit", int'(d), int'(e));
        end
      end else begin
        check(serOut == prevOut, "R5 hold serOut", int'(serOut), int'(prevOut));
        if (!locked)
          check(wordTick == 1'b0, "R5 wordTick low", int'(wordTick), 0);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      nVec++;
      nBad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;               // R7: enable expected after first edge
    runCycles(157);            // several words, ending mid-word
    locked = 1'b0;             // R5: freeze mid-word
    runCycles(7);
    locked = 1'b1;
    runCycles(83);
    locked = 1'b0;             // R5: freeze again, short
    runCycles(2);
    locked = 1'b1;
    runCycles(120);
    rstN = 1'b0;               // R6: reset mid-run
    expQ.delete();
    runCycles(3);
    rstN = 1'b1;
    runCycles(205);
    locked = 1'b0;             // drain check: no more advance
    runCycles(3);
    check(expQ.size() <= WORD_W, "R4 leftover bits", expQ.size(), WORD_W);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule